// File: doc/BRIEF.md
# Address-Programmable Tapped Delay Line

This block delays a single logic signal by a whole number of clock cycles chosen at run time. Each clock edge samples the input into a shift register. A 3-bit address picks one of eight taps on that register. The delay is a fixed base latency plus the address times a per-step increment. Both lengths are parameters, so one instance covers eight evenly spaced delays.

The block drives two outputs: the delayed signal and its complement. Both come from one register stage, so they change on the same edge with no skew between them. An active-low enable forces the two outputs to fixed opposite levels. While the block is disabled the shift register keeps running, so the outputs pick up the stream again as soon as the block is enabled.

The address is not captured. The tap follows the address pins on every edge, and a sequencer outside this block is responsible for keeping the address steady while a pulse is in flight.

Top module: `tdl_delay_line`

## Requirements
- R1: With `en_n` low and `rst` low, the value `din` holds at rising edge k appears on `dout` right after edge k+N, where N = BASE + addr*STEP and `addr` is the value sampled at edge k+N.
- R2: The delay grows strictly with the address. Each address code gives a delay exactly STEP cycles longer than the code one below it, so address 0 gives BASE cycles and address 7 gives BASE+7*STEP cycles.
- R3: `dout_n` is the logical inverse of `dout` after every clock edge, including during reset and while disabled.
- R4: When `en_n` is sampled high at an edge, `dout` is 0 and `dout_n` is 1 right after that edge.
- R5: While the outputs are disabled, the shift register keeps capturing `din`. On the first edge that samples `en_n` low again, the outputs show the input from N cycles earlier, with no extra latency.
- R6: The address is not held in a register. A change on `addr` between two edges selects the new tap at the very next edge.
- R7: A synchronous reset clears every delay stage to 0. Right after a reset edge `dout` is 0 and `dout_n` is 1. Input values that were in flight when the reset arrived never reach the outputs.
- R8: At a constant address, a pulse of W whole cycles on `din` appears on `dout` as a pulse of exactly W cycles, for any W of one cycle or more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Signal to be delayed |
| addr | input | 3 | Live tap select; delay = BASE + addr*STEP cycles |
| en_n | input | 1 | Output enable, active low; high forces the outputs |
| dout | output | 1 | Delayed signal, in phase with `din` |
| dout_n | output | 1 | Inverse of `dout` |

## Verification
The bench sends an isolated one-cycle pulse at each of the eight address codes and measures when it arrives. An off-by-one tap index would show up as every arrival being one cycle early or late. A wrong step multiplier would break the fixed STEP spacing between neighbouring codes.

Three cases stress the state behaviour:
- Disable windows are placed in the middle of live traffic. A design that froze the shift register while disabled would resume with stale data instead of the input from N cycles earlier.
- A reset is issued while the register is full of ones. A design that cleared only the output stage would leak those ones out after the reset.
- The address is changed in the middle of a stream. A design that latched the address would keep using the old tap.

Random stimulus runs against a cycle model that keeps its own history of the input. This catches a swapped complement or gated outputs that do not match.

// File: rtl/tdl_pkg.sv
package tdl_pkg;

    // Width of the live tap-select address.
    localparam int unsigned ADDR_W   = 3;
    // Number of selectable delay settings.
    localparam int unsigned NUM_TAPS = 1 << ADDR_W;

    typedef logic [ADDR_W-1:0] addr_t;

    // Registered output pair: the in-phase value and its complement.
    typedef struct packed {
        logic true_v;
        logic compl_v;
    } outpair_t;

endpackage

// File: rtl/tdl_shift.sv
module tdl_shift #(
    parameter int unsigned LEN = 17
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           din,
    output logic [LEN-1:0] stages
);

    // Stage j holds the din value captured j+1 edges ago.
    typedef struct packed {
        logic [LEN-1:0] sr;
    } shift_state_t;

    shift_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.sr = '0;
        end else begin
            st_d.sr = {st_q.sr[LEN-2:0], din};
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign stages = st_q.sr;

endmodule

// File: rtl/tdl_tap_mux.sv
module tdl_tap_mux
    import tdl_pkg::*;
#(
    parameter int unsigned BASE  = 3,
    parameter int unsigned STEP  = 2,
    parameter int unsigned LEN   = BASE + (NUM_TAPS - 1) * STEP,
    parameter int unsigned IDX_W = $clog2(LEN)
) (
    input  logic [LEN-1:0]   stages,
    input  addr_t            addr,
    output logic             tap,
    output logic [IDX_W-1:0] sel_idx
);

    logic [NUM_TAPS-1:0] cand;

    // Each candidate is a fixed wire to the stage that gives delay BASE + g*STEP
    // once the output register is counted in.
    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        localparam int unsigned STAGE = BASE + g * STEP - 1;
        assign cand[g] = stages[STAGE];
    end

    always_comb begin
        tap     = cand[addr];
        sel_idx = IDX_W'(BASE - 1) + IDX_W'(addr) * IDX_W'(STEP);
    end

endmodule

// File: rtl/tdl_out_stage.sv
module tdl_out_stage
    import tdl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en_n,
    input  logic tap,
    output logic dout,
    output logic dout_n
);

    outpair_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst || en_n) begin
            st_d.true_v  = 1'b0;
            st_d.compl_v = 1'b1;
        end else begin
            st_d.true_v  = tap;
            st_d.compl_v = ~tap;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dout   = st_q.true_v;
    assign dout_n = st_q.compl_v;

    // R3
    complement_pair_chk: assert property (@(posedge clk) disable iff (rst)
        dout_n == ~dout);

    // R4
    disable_force_chk: assert property (@(posedge clk) disable iff (rst)
        en_n |=> (!dout && dout_n));

    // R7
    reset_level_chk: assert property (@(posedge clk)
        rst |=> (!dout && dout_n));

endmodule

// File: rtl/tdl_delay_line.sv
module tdl_delay_line
    import tdl_pkg::*;
#(
    parameter int unsigned BASE = 3,
    parameter int unsigned STEP = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       din,
    input  logic [2:0] addr,
    input  logic       en_n,
    output logic       dout,
    output logic       dout_n
);

    localparam int unsigned LEN   = BASE + (NUM_TAPS - 1) * STEP;
    localparam int unsigned IDX_W = $clog2(LEN);

    logic [LEN-1:0]   stages;
    logic             tap;
    logic [IDX_W-1:0] sel_idx;

    tdl_shift #(
        .LEN (LEN)
    ) i_shift (
        .clk    (clk),
        .rst    (rst),
        .din    (din),
        .stages (stages)
    );

    tdl_tap_mux #(
        .BASE  (BASE),
        .STEP  (STEP),
        .LEN   (LEN),
        .IDX_W (IDX_W)
    ) i_mux (
        .stages  (stages),
        .addr    (addr),
        .tap     (tap),
        .sel_idx (sel_idx)
    );

    tdl_out_stage i_out (
        .clk    (clk),
        .rst    (rst),
        .en_n   (en_n),
        .tap    (tap),
        .dout   (dout),
        .dout_n (dout_n)
    );

    // R2
    monotonic_tap_chk: assert property (@(posedge clk) disable iff (rst)
        (addr > $past(addr)) |-> (sel_idx > $past(sel_idx)));

endmodule

// File: tb/test_tdl_delay_line.sv
module test_tdl_delay_line;

    localparam int BASE = 3;
    localparam int STEP = 2;
    localparam int LEN  = BASE + 7 * STEP;
    localparam int HMAX = 8192;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       din = 1'b0;
    logic [2:0] addr = 3'd0;
    logic       en_n = 1'b0;
    logic       dout, dout_n;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int lrst_cur = -1;

    logic       din_h  [0:HMAX-1];
    logic       rst_h  [0:HMAX-1];
    logic       en_h   [0:HMAX-1];
    logic [2:0] addr_h [0:HMAX-1];
    int         lrst_h [0:HMAX-1];

    always #5 clk = ~clk;

    tdl_delay_line #(.BASE(BASE), .STEP(STEP)) i_tdl_delay_line (
        .clk(clk), .rst(rst), .din(din), .addr(addr),
        .en_n(en_n), .dout(dout), .dout_n(dout_n)
    );

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    function automatic logic model(input int t);
        int n, k;
        if (rst_h[t] || en_h[t]) return 1'b0;
        n = BASE + int'(addr_h[t]) * STEP;
        k = t - n;
        if (k < 0 || k <= lrst_h[t]) return 1'b0;
        return din_h[k];
    endfunction

    // One clock: drive at the falling edge, record at the rising edge,
    // compare at the next falling edge.
    task automatic step(input logic d, input logic e, input logic [2:0] a, input logic r);
        logic exp;
        string tag;
        din = d; en_n = e; addr = a; rst = r;
        @(posedge clk);
        din_h[cyc] = d; en_h[cyc] = e; addr_h[cyc] = a; rst_h[cyc] = r;
        if (r) lrst_cur = cyc;
        lrst_h[cyc] = lrst_cur;
        @(negedge clk);
        exp = model(cyc);
        if (r)                                          tag = "R7";
        else if (e)                                     tag = "R4";
        else if (cyc > 0 && en_h[cyc-1])                tag = "R5";
        else if (cyc > 0 && addr_h[cyc] != addr_h[cyc-1]) tag = "R6";
        else                                            tag = "R1";
        chk(dout === exp, tag, int'(dout), int'(exp));
        chk(dout_n === ~exp, "R3", int'(dout_n), int'(~exp));
        cyc++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int arr, prev, highs;
        void'($urandom(32'd20240611));
        @(negedge clk);

        // Reset state (R7)
        repeat (3) step(1'b0, 1'b0, 3'd0, 1'b1);
        chk(dout === 1'b0 && dout_n === 1'b1, "R7", int'(dout), 0);

        // Arrival time for each address (R1, R2)
        prev = -1;
        for (int a = 0; a < 8; a++) begin
            repeat (LEN + 2) step(1'b0, 1'b0, 3'(a), 1'b0);
            step(1'b1, 1'b0, 3'(a), 1'b0);
            arr = -1;
            for (int i = 1; i <= LEN + 4; i++) begin
                step(1'b0, 1'b0, 3'(a), 1'b0);
                if (dout === 1'b1 && arr < 0) arr = i;
            end
            chk(arr == BASE + a * STEP, "R1", arr, BASE + a * STEP);
            if (a > 0) chk(arr - prev == STEP, "R2", arr - prev, STEP);
            prev = arr;
        end

        // Pulse width preserved (R8)
        for (int w = 1; w <= 5; w++) begin
            repeat (LEN + 2) step(1'b0, 1'b0, 3'd5, 1'b0);
            highs = 0;
            for (int i = 0; i < w + LEN + 4; i++) begin
                step(i < w, 1'b0, 3'd5, 1'b0);
                if (dout === 1'b1) highs++;
            end
            chk(highs == w, "R8", highs, w);
        end

        // Reset drops data in flight (R7)
        repeat (LEN + 2) step(1'b1, 1'b0, 3'd7, 1'b0);
        step(1'b0, 1'b0, 3'd7, 1'b1);
        highs = 0;
        for (int i = 0; i < LEN + 2; i++) begin
            step(1'b0, 1'b0, 3'd7, 1'b0);
            if (dout === 1'b1) highs++;
        end
        chk(highs == 0, "R7", highs, 0);

        // Disable in mid-stream, then resume (R4, R5)
        for (int i = 0; i < 60; i++) step(1'(i % 3 == 0), 1'(i >= 20 && i < 27), 3'd2, 1'b0);

        // Address changes during a stream (R6)
        for (int i = 0; i < 60; i++) step(1'(i % 4 < 2), 1'b0, 3'(i / 8), 1'b0);

        // Constrained random traffic
        begin
            logic [2:0] ra;
            logic re;
            ra = 3'd0;
            re = 1'b0;
            for (int i = 0; i < 2000; i++) begin
                if ($urandom_range(7, 0) == 0) ra = 3'($urandom_range(7, 0));
                if ($urandom_range(9, 0) == 0) re = ~re;
                step(1'($urandom_range(1, 0)), re, ra, 1'($urandom_range(99, 0) == 0));
            end
        end

        finish_run();
    end

endmodule